// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

This block is a bank of sixteen 32-bit mailboxes that lets four processor cores signal one another. Each core owns four mailboxes. A sender never overwrites a mailbox. It writes ones through a set alias, which ORs them in. The receiving core acknowledges by writing ones through a clear alias, which removes exactly those bits. Two separate alias windows make this work without a read-modify-write race between cores.

Every mailbox drives a level interrupt line. The line is high for as long as the mailbox holds a nonzero value. Each core also gets a 32-bit pending word that gathers the interrupt lines of its own four mailboxes. A mailbox that is written while empty keeps the whole 32-bit word unchanged. This lets one mailbox per core carry a start address to a core that is waiting to boot.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox holds zero, every interrupt line is low and every pending word is zero.
- R2: Mailbox b (0..3) of core c (0..3) is written-to-set at byte address 0x80 + 16*c + 4*b and written-to-clear at 0xC0 + 16*c + 4*b. Address bits [1:0] are ignored. Its flat index is m = 4*c + b.
- R3: A write to a set address ORs the written data into the mailbox and leaves bits written as 0 unchanged. The new value is visible from the next clock edge.
- R4: A write to a clear address zeroes every mailbox bit written as 1 and leaves the other bits unchanged.
- R5: A full 32-bit word set into an empty mailbox reads back exactly, bit for bit.
- R6: `mbx_irq[m]` is high exactly while mailbox m is nonzero. It follows the mailbox register, so it changes on the clock edge that applies a write.
- R7: In the pending word of core c (`core_pending[32*c +: 32]`), bit 4+b equals `mbx_irq[4*c+b]` for b = 0..3. All other bits read 0.
- R8: A read at either the set or the clear address of a mailbox returns its current value combinationally. In a cycle that also writes that mailbox, the read shows the value before the write.
- R9: A cycle with `bus_we` low changes no mailbox. A write to an address below 0x80 changes no mailbox, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data (ones select bits to set or clear) |
| bus_rdata | output | 32 | Value of the addressed mailbox, 0 outside both windows |
| mbx_irq | output | 16 | Level interrupt per mailbox, index 4*core + mailbox |
| core_pending | output | 128 | Four 32-bit pending words, core c in bits [32*c+31:32*c] |

## Verification
A read and a write land in the same cycle whenever the bus address points at a mailbox while `bus_we` is high. That cycle therefore carries both a combinational read of the old value and a registered update, and the interrupt level changes only after it. The bench provokes this on every write step and in a long pseudo-random address and data sequence. Within each cycle it compares the read data against a behavioural model that has not yet applied the write, then applies the write at the clock edge. It compares all interrupt lines and pending words against the same model before the next cycle's stimulus.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Bytes covered by one alias window holding `boxes` 32-bit registers.
  function automatic int unsigned window_bytes(int unsigned boxes);
    return boxes * 4;
  endfunction

  // True when a byte address falls inside the window starting at `base`.
  function automatic logic hits_window(int unsigned addr, int unsigned base,
                                       int unsigned boxes);
    return (addr >= base) && (addr < base + window_bytes(boxes));
  endfunction

  // Word slot of an address inside a window; the low two bits are dropped.
  function automatic int unsigned slot_of(int unsigned addr, int unsigned base);
    return (addr - base) >> 2;
  endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_BOX  = 16,
  parameter int unsigned SET_BASE = 'h80,
  parameter int unsigned CLR_BASE = 'hC0,
  localparam int unsigned IDX_W   = $clog2(NUM_BOX)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              set_hit,
  output logic              clr_hit,
  output logic [IDX_W-1:0]  idx
);

  int unsigned a_wide;

  always_comb begin
    a_wide  = 32'(addr);
    set_hit = hits_window(a_wide, SET_BASE, NUM_BOX);
    clr_hit = hits_window(a_wide, CLR_BASE, NUM_BOX);
    if (set_hit)
      idx = IDX_W'(slot_of(a_wide, SET_BASE));
    else if (clr_hit)
      idx = IDX_W'(slot_of(a_wide, CLR_BASE));
    else
      idx = '0;
  end

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              irq
);

  // Set first, then clear, so a clear always wins on a shared bit.
  function automatic logic [DATA_W-1:0] apply_write(
    input logic [DATA_W-1:0] cur,
    input logic              s,
    input logic              c,
    input logic [DATA_W-1:0] wd
  );
    logic [DATA_W-1:0] after_set;
    after_set = s ? (cur | wd) : cur;
    return c ? (after_set & ~wd) : after_set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      value <= '0;
    else if (set_en || clr_en)
      value <= apply_write(value, set_en, clr_en, wdata);
  end

  assign irq = |value;

endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned BOXES_PER_CORE = 4,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned PEND_LSB       = 4,
  localparam int unsigned NUM_BOX       = NUM_CORES * BOXES_PER_CORE
) (
  input  logic [NUM_BOX-1:0]          irq,
  output logic [NUM_CORES*DATA_W-1:0] pending
);

  always_comb begin
    pending = '0;
    for (int c = 0; c < int'(NUM_CORES); c++)
      for (int b = 0; b < int'(BOXES_PER_CORE); b++)
        pending[c*DATA_W + PEND_LSB + b] = irq[c*BOXES_PER_CORE + b];
  end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned BOXES_PER_CORE = 4,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter int unsigned SET_BASE       = 'h80,
  parameter int unsigned CLR_BASE       = 'hC0,
  parameter int unsigned PEND_LSB       = 4,
  localparam int unsigned NUM_BOX       = NUM_CORES * BOXES_PER_CORE,
  localparam int unsigned IDX_W         = $clog2(NUM_BOX)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_BOX-1:0]          mbx_irq,
  output logic [NUM_CORES*DATA_W-1:0] core_pending
);

  logic                      set_hit;
  logic                      clr_hit;
  logic [IDX_W-1:0]          hit_idx;
  // Named per-mailbox events, brought out for the checker.
  logic [NUM_BOX-1:0]        set_evt;
  logic [NUM_BOX-1:0]        clr_evt;
  logic [NUM_BOX*DATA_W-1:0] box_flat;

  mbx_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_BOX (NUM_BOX),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
  ) u_decode (
    .addr   (bus_addr),
    .set_hit(set_hit),
    .clr_hit(clr_hit),
    .idx    (hit_idx)
  );

  for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
    assign set_evt[m] = bus_we && set_hit && (hit_idx == IDX_W'(m));
    assign clr_evt[m] = bus_we && clr_hit && (hit_idx == IDX_W'(m));

    mbx_cell #(.DATA_W(DATA_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_en(set_evt[m]),
      .clr_en(clr_evt[m]),
      .wdata (bus_wdata),
      .value (box_flat[m*DATA_W +: DATA_W]),
      .irq   (mbx_irq[m])
    );
  end

  always_comb begin
    if (set_hit || clr_hit)
      bus_rdata = box_flat[hit_idx*DATA_W +: DATA_W];
    else
      bus_rdata = '0;
  end

  mbx_status #(
    .NUM_CORES     (NUM_CORES),
    .BOXES_PER_CORE(BOXES_PER_CORE),
    .DATA_W        (DATA_W),
    .PEND_LSB      (PEND_LSB)
  ) u_status (
    .irq    (mbx_irq),
    .pending(core_pending)
  );

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned BOXES_PER_CORE = 4,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned PEND_LSB       = 4,
  localparam int unsigned NUM_BOX       = NUM_CORES * BOXES_PER_CORE
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [NUM_BOX-1:0]          set_evt,
  input logic [NUM_BOX-1:0]          clr_evt,
  input logic [NUM_BOX*DATA_W-1:0]   box_flat,
  input logic [NUM_BOX-1:0]          mbx_irq,
  input logic [NUM_CORES*DATA_W-1:0] core_pending
);

  localparam logic [DATA_W-1:0] SLOT_MASK =
    ((DATA_W'(1) << BOXES_PER_CORE) - DATA_W'(1)) << PEND_LSB;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_evt, clr_evt})); // R2

  for (genvar m = 0; m < NUM_BOX; m++) begin : g_box_chk
    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[m] && !clr_evt[m] |=>
        ((box_flat[m*DATA_W +: DATA_W] & $past(bus_wdata)) == $past(bus_wdata))); // R3
    AST_CLR_DROPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_evt[m] |=> ((box_flat[m*DATA_W +: DATA_W] & $past(bus_wdata)) == '0)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !set_evt[m] && !clr_evt[m] |=> $stable(box_flat[m*DATA_W +: DATA_W])); // R9
    AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_irq[m] && !clr_evt[m] |=> mbx_irq[m]); // R6
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    AST_PEND_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pending[c*DATA_W +: DATA_W] & ~SLOT_MASK) == '0); // R7
    for (genvar b = 0; b < BOXES_PER_CORE; b++) begin : g_slot_chk
      AST_PEND_FOLLOWS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        core_pending[c*DATA_W + PEND_LSB + b] == mbx_irq[c*BOXES_PER_CORE + b]); // R7
    end
  end

endmodule

bind mbx_bank mbx_bank_chk #(
  .NUM_CORES     (NUM_CORES),
  .BOXES_PER_CORE(BOXES_PER_CORE),
  .DATA_W        (DATA_W),
  .PEND_LSB      (PEND_LSB)
) u_mbx_bank_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wdata   (bus_wdata),
  .set_evt     (set_evt),
  .clr_evt     (clr_evt),
  .box_flat    (box_flat),
  .mbx_irq     (mbx_irq),
  .core_pending(core_pending)
);

// File: tb/test_mbx_bank.sv
module test_mbx_bank;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   addr  = '0;
  logic         we    = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [15:0]  irq;
  logic [127:0] pend;

  always #4 clk = ~clk;  // 125 MHz

  mbx_bank i_mbx_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (addr),
    .bus_we      (we),
    .bus_wdata   (wdata),
    .bus_rdata   (rdata),
    .mbx_irq     (irq),
    .core_pending(pend)
  );

  logic [31:0] model [16];
  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Window 0x80..0xBF is a[7:6]==2, 0xC0..0xFF is a[7:6]==3; slot is a[5:2].
  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a[7]) return model[a[5:2]];
    return 32'h0;
  endfunction

  function automatic logic [15:0] model_irq();
    logic [15:0] r;
    foreach (model[i]) r[i] = (model[i] != 0);
    return r;
  endfunction

  function automatic logic [127:0] model_pend();
    logic [127:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        if (model[c*4+b] != 0) r[c*32 + 4 + b] = 1'b1;
    return r;
  endfunction

  task automatic compare_levels();
    check(irq == model_irq(), "R6 irq", 128'(irq), 128'(model_irq()));
    check(pend == model_pend(), "R7 pending", pend, model_pend());
  endtask

  // One bus cycle: levels checked before drive, read checked against the
  // pre-write model, write applied to the model at the clock edge.
  task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                      input string tag);
    @(negedge clk);
    compare_levels();
    addr = a; we = w; wdata = d;
    #1;
    check(rdata == model_read(a), tag, 128'(rdata), 128'(model_read(a)));
    @(posedge clk);
    if (w && a[7]) begin
      if (!a[6]) model[a[5:2]] = model[a[5:2]] | d;
      else       model[a[5:2]] = model[a[5:2]] & ~d;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned s;
    foreach (model[i]) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    check(irq == 16'h0, "R1 irq", 128'(irq), 0);
    check(pend == 128'h0, "R1 pending", pend, 0);
    for (int m = 0; m < 16; m++) step(1'b0, 8'(8'h80 + 4*m), 32'h0, "R1");

    // R2: address map, set via one alias, read via the other
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        step(1'b1, 8'(8'h80 + 16*c + 4*b), 32'(32'h0001_0000 + 16*c + b + 1), "R8");
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 4; b++)
        step(1'b0, 8'(8'hC0 + 16*c + 4*b), 32'h0, "R2");

    // R3: ORing (mailbox 1 of core 1)
    step(1'b1, 8'hD4, 32'hFFFF_FFFF, "R8");
    step(1'b1, 8'h94, 32'h0000_00F0, "R8");
    step(1'b1, 8'h94, 32'h0000_0F0F, "R8");
    step(1'b0, 8'h94, 32'h0, "R3");
    // R4: selective clear
    step(1'b1, 8'hD4, 32'h0000_0F00, "R8");
    step(1'b0, 8'hD4, 32'h0, "R4");

    // R5: full word in mailbox 3 of core 2
    step(1'b1, 8'hEC, 32'hFFFF_FFFF, "R8");
    step(1'b1, 8'hAC, 32'h8000_0040, "R8");
    step(1'b0, 8'hAC, 32'h0, "R5");
    step(1'b0, 8'hEC, 32'h0, "R5");

    // R9: no effect without enable or outside the windows
    step(1'b0, 8'h84, 32'hFFFF_FFFF, "R9");
    step(1'b0, 8'hC4, 32'hFFFF_FFFF, "R9");
    step(1'b0, 8'h84, 32'h0, "R9");
    step(1'b1, 8'h10, 32'hFFFF_FFFF, "R9");
    step(1'b1, 8'h7C, 32'hFFFF_FFFF, "R9");
    step(1'b0, 8'h7C, 32'h0, "R9");
    step(1'b0, 8'h40, 32'h0, "R9");
    for (int m = 0; m < 16; m++) step(1'b0, 8'(8'h80 + 4*m), 32'h0, "R9");

    // R6: clear everything, lines must fall
    for (int m = 0; m < 16; m++) step(1'b1, 8'(8'hC0 + 4*m), 32'hFFFF_FFFF, "R8");
    step(1'b0, 8'h00, 32'h0, "R6");

    // R8: pseudo-random mix, reads overlap writes in the same cycle
    s = 32'h1357_9BDF;
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      a = {s[7:2], 2'b00};
      if (s[9:8] == 2'b00) a[7] = 1'b0;
      else                 a[7] = 1'b1;
      step(s[10] | s[11], a, {s[31:12], s[11:0] ^ s[23:12]}, a[7] ? "R8" : "R9");
    end
    step(1'b0, 8'h80, 32'h0, "R8");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule